// File: doc/BRIEF.md
# Redundant Unary Product-Stream Multiplier

This block multiplies two small unsigned factors so that the answer survives many bit flips at once. Each factor is first scaled by 2^K by appending K zero bits below its least significant bit. The block then walks a square array whose cells are the ANDs of every pairing of bits from the unary (thermometer) forms of the two scaled factors. One cell is emitted per clock as a serial stream. Because the factors are scaled, each unit of the true product is carried by 2^R ones in the stream, where R = 2K.

A fixed group of 2^(R-1) bias ones is placed in a part of the array that the factors can never reach, so the stream length stays at (2^(F+K)-1)^2. The ones are counted while the stream is emitted, and the product is that count shifted right by R. An unmatched flip moves the count by one, and the bias keeps the integer quotient unchanged across a window of such moves. A flip mask input, captured at start, inverts chosen stream positions before they are counted, so that faults can be injected on purpose. The parameters must satisfy K <= F so that the bias fits in the final array row.

Top module: `rmul_top`

## Requirements
- R1: After reset, done and stream_valid are low and product is zero.
- R2: A start pulse while idle makes stream_valid high for exactly L = (2^(F+K)-1)^2 consecutive cycles, the first being the cycle after the start edge.
- R3: Stream position i, counted from 0 in emission order, has row i/U and column i%U with U = 2^(F+K)-1. Its value is 1 when row < A*2^K and column < B*2^K, or when row = U-1 and column < 2^(R-1); this value is then XORed with bit i of flip_mask.
- R4: With a zero flip mask, the stream holds A*B*2^R + 2^(R-1) ones and product equals A*B.
- R5: done is high for one cycle only, in the cycle after the last stream bit; product is valid then and stays unchanged until the next accepted start.
- R6: Up to 2^(R-1)-1 net flips from 0 to 1 leave product equal to A*B.
- R7: Up to 2^(R-1) net flips from 1 to 0 leave product equal to A*B.
- R8: Any number of flips that come in 0-to-1 and 1-to-0 pairs leave product equal to A*B.
- R9: A start pulse during a run has no effect: the stream keeps its length and content and product comes from the operands captured first.
- R10: product always equals the ones count divided by 2^R, rounded down, so 2^(R-1) net upward flips give A*B+1 and 2^(R-1)+1 net downward flips give A*B-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| a | input | F | First factor |
| b | input | F | Second factor |
| flip_mask | input | L | Per-position inversion mask, bit i acts on stream position i |
| stream_bit | output | 1 | Current serial product stream bit after injection |
| stream_valid | output | 1 | High while stream_bit carries a stream position |
| product | output | 2F | Count of stream ones shifted right by R |
| done | output | 1 | One-cycle pulse after the final stream bit |

## Verification
The assertions assume that start is only acted on from the idle state and that the flip mask and operands matter only at the accepting edge; they then hold the run length, the done pulse and the hold of product without knowing the factor values. The stimulus raises start for a single cycle at each operation, and one case raises it again mid-run to show it is ignored. Flip masks are built in the bench from the R3 cell rule so that each injected flip lands on a known zero or one, which keeps the net flip count inside, or deliberately just outside, the tolerance window.

// File: rtl/rmul_pkg.sv
package rmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rmul_state_e;

    // Side length of the unary array for a scaled factor of the given width
    function automatic int side_len(input int scaled_w);
        return (1 << scaled_w) - 1;
    endfunction

    // Number of stream positions in the whole array
    function automatic int stream_len(input int scaled_w);
        return side_len(scaled_w) * side_len(scaled_w);
    endfunction

endpackage

// File: rtl/rmul_seq.sv
module rmul_seq
    import rmul_pkg::*;
#(
    parameter int F = 2,
    parameter int K = 2,
    localparam int S  = F + K,
    localparam int U  = side_len(S),
    localparam int L  = stream_len(S),
    localparam int IW = $clog2(L)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [F-1:0] a,
    input  logic [F-1:0] b,
    input  logic [L-1:0] mask_in,
    output logic         run,
    output logic         fin,
    output logic         clear,
    output logic [S-1:0] row,
    output logic [S-1:0] col,
    output logic [S-1:0] sa,
    output logic [S-1:0] sb,
    output logic         mask_bit
);

    localparam logic [IW-1:0] LAST_IDX = IW'(L - 1);
    localparam logic [S-1:0]  LAST_COL = S'(U - 1);

    typedef struct packed {
        rmul_state_e    st;
        logic [S-1:0]   row;
        logic [S-1:0]   col;
        logic [IW-1:0]  idx;
        logic [S-1:0]   sa;
        logic [S-1:0]   sb;
        logic [L-1:0]   mask;
    } seq_t;

    seq_t seq_d, seq_q;
    logic clear_d;

    always_comb begin
        seq_d   = seq_q;
        clear_d = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st   = ST_RUN;
                    seq_d.row  = '0;
                    seq_d.col  = '0;
                    seq_d.idx  = '0;
                    seq_d.sa   = {a, {K{1'b0}}};
                    seq_d.sb   = {b, {K{1'b0}}};
                    seq_d.mask = mask_in;
                    clear_d    = 1'b1;
                end
            end
            ST_RUN: begin
                seq_d.idx = seq_q.idx + 1'b1;
                if (seq_q.col == LAST_COL) begin
                    seq_d.col = '0;
                    seq_d.row = seq_q.row + 1'b1;
                end else begin
                    seq_d.col = seq_q.col + 1'b1;
                end
                if (seq_q.idx == LAST_IDX) begin
                    seq_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                seq_d.st = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run      = (seq_q.st == ST_RUN);
    assign fin      = (seq_q.st == ST_DONE);
    assign clear    = clear_d;
    assign row      = seq_q.row;
    assign col      = seq_q.col;
    assign sa       = seq_q.sa;
    assign sb       = seq_q.sb;
    assign mask_bit = seq_q.mask[seq_q.idx];

endmodule

// File: rtl/rmul_cell.sv
module rmul_cell
    import rmul_pkg::*;
#(
    parameter int F = 2,
    parameter int K = 2,
    localparam int S    = F + K,
    localparam int U    = side_len(S),
    localparam int R    = 2 * K,
    localparam int BIAS = 1 << (R - 1)
) (
    input  logic [S-1:0] row,
    input  logic [S-1:0] col,
    input  logic [S-1:0] sa,
    input  logic [S-1:0] sb,
    input  logic         mask_bit,
    output logic         bit_out
);

    localparam logic [S-1:0] LAST_ROW = S'(U - 1);
    localparam logic [S-1:0] BIAS_COL = S'(BIAS);

    logic prod_cell;
    logic bias_cell;

    // Unary AND array: the cell is set when both thermometer codes are set
    assign prod_cell = (row < sa) && (col < sb);
    // Bias ones sit in the last row, which no scaled factor reaches
    assign bias_cell = (row == LAST_ROW) && (col < BIAS_COL);
    assign bit_out   = (prod_cell | bias_cell) ^ mask_bit;

endmodule

// File: rtl/rmul_tally.sv
module rmul_tally #(
    parameter int CW = 8,
    parameter int R  = 4,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          bit_in,
    output logic [PW-1:0] product
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tally_t;

    tally_t tally_d, tally_q;

    always_comb begin
        tally_d = tally_q;
        if (clear) begin
            tally_d.cnt = '0;
        end else if (run) begin
            tally_d.cnt = tally_q.cnt + CW'(bit_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_d;
        end
    end

    // Integer quotient by a power of two
    assign product = PW'(tally_q.cnt >> R);

endmodule

// File: rtl/rmul_top.sv
module rmul_top
    import rmul_pkg::*;
#(
    parameter int F = 2,
    parameter int K = 2,
    localparam int S  = F + K,
    localparam int L  = stream_len(S),
    localparam int R  = 2 * K,
    localparam int CW = $clog2(L + 1),
    localparam int PW = 2 * F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [F-1:0]  a,
    input  logic [F-1:0]  b,
    input  logic [L-1:0]  flip_mask,
    output logic          stream_bit,
    output logic          stream_valid,
    output logic [PW-1:0] product,
    output logic          done
);

    logic         run;
    logic         fin;
    logic         clear;
    logic [S-1:0] row;
    logic [S-1:0] col;
    logic [S-1:0] sa;
    logic [S-1:0] sb;
    logic         mask_bit;
    logic         cell_bit;

    rmul_seq #(.F(F), .K(K)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .a        (a),
        .b        (b),
        .mask_in  (flip_mask),
        .run      (run),
        .fin      (fin),
        .clear    (clear),
        .row      (row),
        .col      (col),
        .sa       (sa),
        .sb       (sb),
        .mask_bit (mask_bit)
    );

    rmul_cell #(.F(F), .K(K)) u_cell (
        .row      (row),
        .col      (col),
        .sa       (sa),
        .sb       (sb),
        .mask_bit (mask_bit),
        .bit_out  (cell_bit)
    );

    rmul_tally #(.CW(CW), .R(R), .PW(PW)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .run     (run),
        .bit_in  (cell_bit),
        .product (product)
    );

    assign stream_bit   = run & cell_bit;
    assign stream_valid = run;
    assign done         = fin;

endmodule

// File: rtl/rmul_chk.sv
module rmul_chk
    import rmul_pkg::*;
#(
    parameter int F = 2,
    parameter int K = 2,
    localparam int S  = F + K,
    localparam int L  = stream_len(S),
    localparam int LW = $clog2(L + 1) + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           stream_valid,
    input logic           done,
    input logic [2*F-1:0] product
);

    logic [LW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (stream_valid) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R2 R9
    stream_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stream_valid) |-> (run_len == LW'(L)));

    // R2 R9
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stream_valid |-> (run_len < LW'(L)));

    // R5
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stream_valid) |-> done);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stream_valid && !start) |=> $stable(product));

    // R5
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !stream_valid);

endmodule

bind rmul_top rmul_chk #(.F(F), .K(K)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .stream_valid (stream_valid),
    .done         (done),
    .product      (product)
);

// File: tb/tb_rmul_top.sv
`timescale 1ns/1ps
module tb_rmul_top;

    localparam int F    = 2;
    localparam int K    = 2;
    localparam int S    = F + K;
    localparam int U    = (1 << S) - 1;
    localparam int L    = U * U;
    localparam int R    = 2 * K;
    localparam int BIAS = 1 << (R - 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [F-1:0]   a_i = '0;
    logic [F-1:0]   b_i = '0;
    logic [L-1:0]   mask_i = '0;
    logic           stream_bit;
    logic           stream_valid;
    logic [2*F-1:0] product;
    logic           done;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    rmul_top #(.F(F), .K(K)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .a            (a_i),
        .b            (b_i),
        .flip_mask    (mask_i),
        .stream_bit   (stream_bit),
        .stream_valid (stream_valid),
        .product      (product),
        .done         (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // Cell rule from R3, before injection
    function automatic bit ref_bit(input int a, input int b, input int i);
        int row = i / U;
        int col = i % U;
        return ((row < (a << K)) && (col < (b << K))) || ((row == U - 1) && (col < BIAS));
    endfunction

    function automatic logic [L-1:0] make_mask(input int a, input int b, input int n_up, input int n_dn);
        logic [L-1:0] m = '0;
        int up = 0;
        int dn = 0;
        for (int i = 0; i < L; i++) begin
            if (!ref_bit(a, b, i) && up < n_up) begin
                m[i] = 1'b1;
                up++;
            end else if (ref_bit(a, b, i) && dn < n_dn) begin
                m[i] = 1'b1;
                dn++;
            end
        end
        return m;
    endfunction

    task automatic run_op(input int a, input int b, input int n_up, input int n_dn,
                          input int exp_prod, input bit restart, input string req);
        logic [L-1:0] m = make_mask(a, b, n_up, n_dn);
        int n = 0;
        int ones = 0;
        int mism = 0;
        int guard = 0;
        bit prev_v = 1'b0;
        int held;
        @(negedge clk);
        a_i = F'(a);
        b_i = F'(b);
        mask_i = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(stream_valid === 1'b1, "R2 first bit follows start", int'(stream_valid), 1);
        while (done !== 1'b1 && guard < L + 20) begin
            if (stream_valid === 1'b1) begin
                if (stream_bit !== (ref_bit(a, b, n) ^ m[n])) mism++;
                ones += int'(stream_bit);
                n++;
            end
            prev_v = stream_valid;
            start = (restart && n == 50);
            if (restart) begin
                a_i = F'(3 - a);
                mask_i = ~m;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        check(done === 1'b1 && prev_v, "R5 done right after last bit", int'(done), 1);
        check(n == L, "R2 stream length", n, L);
        check(mism == 0, "R3 stream content", mism, 0);
        check(ones == a * b * (1 << R) + BIAS + n_up - n_dn, "R4 ones count", ones,
              a * b * (1 << R) + BIAS + n_up - n_dn);
        check(int'(product) == exp_prod, req, int'(product), exp_prod);
        held = int'(product);
        @(negedge clk);
        check(done === 1'b0 && int'(product) == held, "R5 single done and held product",
              int'(done), 0);
    endtask

    initial begin
        #(20 * 150000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done === 1'b0, "R1 done low", int'(done), 0);
        check(stream_valid === 1'b0, "R1 stream_valid low", int'(stream_valid), 0);
        check(product === '0, "R1 product zero", int'(product), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 exhaustive sweep, no injection
        for (int a = 0; a < (1 << F); a++) begin
            for (int b = 0; b < (1 << F); b++) begin
                run_op(a, b, 0, 0, a * b, 1'b0, "R4 product");
            end
        end

        // R6 upward flips at the limit
        run_op(3, 3, BIAS - 1, 0, 9, 1'b0, "R6 up flips 3x3");
        run_op(2, 1, BIAS - 1, 0, 2, 1'b0, "R6 up flips 2x1");
        run_op(0, 0, BIAS - 1, 0, 0, 1'b0, "R6 up flips 0x0");

        // R7 downward flips at the limit
        run_op(3, 3, 0, BIAS, 9, 1'b0, "R7 down flips 3x3");
        run_op(1, 1, 0, BIAS, 1, 1'b0, "R7 down flips 1x1");
        run_op(0, 2, 0, BIAS, 0, 1'b0, "R7 down flips 0x2");

        // R8 complementary pairs
        run_op(3, 2, 40, 40, 6, 1'b0, "R8 pairs 3x2");
        run_op(1, 3, 50, 50, 3, 1'b0, "R8 pairs 1x3");

        // R10 just beyond the window
        run_op(2, 2, BIAS, 0, 5, 1'b0, "R10 one up flip too many");
        run_op(2, 3, 0, BIAS + 1, 5, 1'b0, "R10 one down flip too many");

        // R9 start during a run is ignored
        run_op(2, 3, 0, 0, 6, 1'b1, "R9 restart ignored");
        run_op(1, 2, 3, 2, 2, 1'b1, "R9 restart ignored with flips");

        report();
    end

endmodule